// File: doc/BRIEF.md
# Multi-mode ultrasonic burst sequencer

This block sequences transmit bursts for a two-output transducer driver. The drive waveform is not made inside the block: two external clock-like pins, `io1` and `io2`, carry it, and during a burst the two drive outputs copy those pins. A 2-bit mode input picks one of four policies for how a burst is armed, started and ended. The arm event can be a software trigger bit, an `io1` falling edge, any falling edge, or an `io2` falling edge. Once armed, toggling starts only on the next falling edge of the chosen pin.

The pins are resynchronised to the internal clock. Falling edges of `io2` are counted against a programmable pulse count, and a count of zero gives continuous bursting in the trigger-bit and `io1`-gated modes. In the two-pin mode, a stretch where both pins are high ends the burst and disarms it. In the self-starting mode, a blank-out interval follows each burst. Outside a burst the block reports listening, and both drive outputs are held low.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted and on release, `busy`, `outA`, `outB` and `burstDone` are all 0.
- R2: While `busy` is 0, `outA` and `outB` are 0. While `busy` is 1, `outA` equals `io1` and `outB` equals `io2`, each delayed by the two synchroniser stages.
- R3: Mode 2'b00: a 0-to-1 change of `trigger` arms the burst. The next `io2` falling edge starts it. The burst ends once `pulseCount` further `io2` falling edges have been seen after the start edge.
- R4: Mode 2'b00: clearing `trigger` ends an armed or active burst at once. After any end, a new burst needs `trigger` to go low and then high again. `io2` edges while `trigger` stays high do nothing.
- R5: Mode 2'b01: an `io1` falling edge arms the burst and the next `io2` falling edge starts it. The burst ends on the pulse count or when `io1` rises, whichever comes first.
- R6: In modes 2'b00 and 2'b01, `pulseCount` = 0 means no pulse limit. The burst then ends only through `trigger` or `io1`.
- R7: Mode 2'b10: a falling edge on either pin arms the burst. The burst starts only at a later `io1` falling edge, and `pulseCount` has no effect.
- R8: Mode 2'b10: during a burst, if both synchronised pins are high for `OVL_CYC` consecutive clocks, the burst ends and the block disarms. The falling edge that follows only arms the block and does not start a burst.
- R9: Mode 2'b11: one `io2` falling edge both arms and starts the burst. The burst ends only on the pulse count, and a count of 0 acts as 1.
- R10: Mode 2'b11: after each burst ends, `io2` falling edges are ignored for `blankCycles` clocks. After that interval a new burst can start.
- R11: `burstDone` is a single-cycle pulse, high in the first cycle that `busy` is 0 after a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Burst policy select |
| trigger | input | 1 | Software arm bit (mode 2'b00) |
| pulseCount | input | PULSE_W | Pulses per burst (0 = continuous in modes 0/1) |
| blankCycles | input | BLANK_W | Blank-out length after a burst in mode 2'b11 |
| io1 | input | 1 | External drive pin 1 (asynchronous) |
| io2 | input | 1 | External drive pin 2 (asynchronous) |
| outA | output | 1 | Drive output A |
| outB | output | 1 | Drive output B |
| busy | output | 1 | 1 while bursting, 0 while listening |
| burstDone | output | 1 | One-cycle end-of-burst pulse |

## Verification
A pin change shows on `outA`/`outB` after two rising clock edges, once the synchronisers have passed it. An edge that moves the sequencer changes `busy` and `burstDone` on the third rising edge. A `trigger` change acts on the first edge. The bench drives every input on a falling clock edge and holds each pin level for four clocks before the next step. Output checks come at least three edges after the last pin change, so every result is settled before it is sampled. Done pulses are counted by a monitor on every falling edge, which catches a pulse that occurs between two checks.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_ARMED  = 2'd1,
    S_ACTIVE = 2'd2,
    S_BLANK  = 2'd3
  } seqState_t;

  localparam logic [1:0] MODE_TRIG = 2'd0;
  localparam logic [1:0] MODE_IO1  = 2'd1;
  localparam logic [1:0] MODE_DUAL = 2'd2;
  localparam logic [1:0] MODE_AUTO = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic blankLoad;
    logic ovlEn;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic fall1;
    logic fall2;
    logic rise1;
    logic trigRise;
    logic lvl1;
    logic lvl2;
    logic cntLast;
    logic ovlHit;
    logic blankDone;
  } dpStat_t;

endpackage

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int PULSE_W     = 8,
  parameter int BLANK_W     = 8,
  parameter int OVL_CYC     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic               trigger,
  input  logic [PULSE_W-1:0] pulseCount,
  input  logic [BLANK_W-1:0] blankCycles,
  input  logic [1:0]         pins,
  input  dpCtrl_t            ctl,
  output dpStat_t            st
);

  localparam int CW = PULSE_W + 1;
  localparam int OW = $clog2(OVL_CYC + 1);

  logic [SYNC_STAGES-1:0] shReg [2];
  logic [1:0] lvl;
  logic [1:0] lvlPrev;

  // per-pin synchroniser, idle level high
  for (genvar g = 0; g < 2; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg[g]   <= '1;
        lvlPrev[g] <= 1'b1;
      end else begin
        shReg[g]   <= {shReg[g][SYNC_STAGES-2:0], pins[g]};
        lvlPrev[g] <= lvl[g];
      end
    end
    assign lvl[g] = shReg[g][SYNC_STAGES-1];
  end

  logic trigPrev;
  always_ff @(posedge clk) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trigger;
  end

  // pulse counter
  logic [PULSE_W-1:0] pulseCnt;
  logic [PULSE_W-1:0] effLimit;
  logic               countOn;

  always_comb begin
    effLimit = pulseCount;
    if (mode == MODE_AUTO && pulseCount == '0) effLimit = PULSE_W'(1);
    countOn = (effLimit != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           pulseCnt <= '0;
    else if (ctl.cntClr) pulseCnt <= '0;
    else if (ctl.cntInc) pulseCnt <= pulseCnt + 1'b1;
  end

  // overlap run-length counter
  logic [OW-1:0] ovlCnt;
  logic          bothHigh;
  assign bothHigh = lvl[0] & lvl[1];

  always_ff @(posedge clk) begin
    if (!rstN)                    ovlCnt <= '0;
    else if (!ctl.ovlEn || !bothHigh) ovlCnt <= '0;
    else if (ovlCnt != OW'(OVL_CYC)) ovlCnt <= ovlCnt + 1'b1;
  end

  // blank-out timer
  logic [BLANK_W-1:0] blankCnt;
  always_ff @(posedge clk) begin
    if (!rstN)              blankCnt <= '0;
    else if (ctl.blankLoad) blankCnt <= blankCycles;
    else if (blankCnt != '0) blankCnt <= blankCnt - 1'b1;
  end

  always_comb begin
    st.lvl1      = lvl[0];
    st.lvl2      = lvl[1];
    st.fall1     = lvlPrev[0] & ~lvl[0];
    st.fall2     = lvlPrev[1] & ~lvl[1];
    st.rise1     = ~lvlPrev[0] & lvl[0];
    st.trigRise  = trigger & ~trigPrev;
    st.cntLast   = countOn && (({1'b0, pulseCnt} + CW'(1)) == {1'b0, effLimit});
    st.ovlHit    = ctl.ovlEn && bothHigh && (ovlCnt == OW'(OVL_CYC - 1));
    st.blankDone = (blankCnt == '0);
  end

  // R10: a loaded timer counts down by one per cycle
  a_r10_blank_down: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.blankLoad && blankCnt != '0) |=> blankCnt == $past(blankCnt) - 1'b1);

endmodule

// File: rtl/burst_seq_ctl.sv
module burst_seq_ctl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       trigger,
  input  dpStat_t    st,
  output dpCtrl_t    ctl,
  output logic       busy,
  output logic       burstDone
);

  seqState_t state, stateNext;
  logic      endNow;
  logic      startNow;
  logic      doneQ;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    endNow    = 1'b0;
    startNow  = 1'b0;
    unique case (state)
      S_IDLE: begin
        unique case (mode)
          MODE_TRIG: if (st.trigRise) stateNext = S_ARMED;
          MODE_IO1:  if (st.fall1) stateNext = S_ARMED;
          MODE_DUAL: if (st.fall1 || st.fall2) stateNext = S_ARMED;
          default:   if (st.fall2) startNow = 1'b1;
        endcase
      end
      S_ARMED: begin
        unique case (mode)
          MODE_TRIG: if (!trigger) stateNext = S_IDLE;
                     else if (st.fall2) startNow = 1'b1;
          MODE_IO1:  if (st.rise1) stateNext = S_IDLE;
                     else if (st.fall2) startNow = 1'b1;
          MODE_DUAL: if (st.fall1) startNow = 1'b1;
          default:   stateNext = S_IDLE;
        endcase
      end
      S_ACTIVE: begin
        ctl.ovlEn = (mode == MODE_DUAL);
        unique case (mode)
          MODE_TRIG: if (!trigger) endNow = 1'b1;
                     else if (st.fall2) begin
                       ctl.cntInc = 1'b1;
                       endNow     = st.cntLast;
                     end
          MODE_IO1:  if (st.rise1) endNow = 1'b1;
                     else if (st.fall2) begin
                       ctl.cntInc = 1'b1;
                       endNow     = st.cntLast;
                     end
          MODE_DUAL: endNow = st.ovlHit;
          default:   if (st.fall2) begin
                       ctl.cntInc    = 1'b1;
                       endNow        = st.cntLast;
                       ctl.blankLoad = st.cntLast;
                     end
        endcase
        if (endNow) stateNext = (mode == MODE_AUTO) ? S_BLANK : S_IDLE;
      end
      default: if (st.blankDone) stateNext = S_IDLE;
    endcase
    if (startNow) begin
      stateNext  = S_ACTIVE;
      ctl.cntClr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= (state == S_ACTIVE) && (stateNext != S_ACTIVE);
    end
  end

  assign busy      = (state == S_ACTIVE);
  assign burstDone = doneQ;

  // R11: done lasts one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R11: done only after an active cycle
  a_r11_done_after_burst: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(state) == S_ACTIVE);
  // R10: no start straight out of blank-out
  a_r10_blank_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BLANK) |=> (state != S_ACTIVE));
  // R8: overlap ends and disarms
  a_r8_ovl_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACTIVE && mode == MODE_DUAL && st.ovlHit) |=> state == S_IDLE);
  // R7: an io2 edge alone never starts a two-pin burst
  a_r7_dual_io1_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ARMED && mode == MODE_DUAL && st.fall2 && !st.fall1) |=> state == S_ARMED);
  // R9: one io2 edge arms and starts in self-starting mode
  a_r9_auto_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && mode == MODE_AUTO && st.fall2) |=> state == S_ACTIVE);

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int PULSE_W     = 8,
  parameter int BLANK_W     = 8,
  parameter int OVL_CYC     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic               trigger,
  input  logic [PULSE_W-1:0] pulseCount,
  input  logic [BLANK_W-1:0] blankCycles,
  input  logic               io1,
  input  logic               io2,
  output logic               outA,
  output logic               outB,
  output logic               busy,
  output logic               burstDone
);

  dpCtrl_t ctl;
  dpStat_t st;

  burst_seq_dp #(
    .PULSE_W(PULSE_W), .BLANK_W(BLANK_W),
    .OVL_CYC(OVL_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .trigger(trigger),
    .pulseCount(pulseCount), .blankCycles(blankCycles),
    .pins({io2, io1}), .ctl(ctl), .st(st)
  );

  burst_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .mode(mode), .trigger(trigger),
    .st(st), .ctl(ctl), .busy(busy), .burstDone(burstDone)
  );

  assign outA = busy & st.lvl1;
  assign outB = busy & st.lvl2;

  // R4: clearing the trigger leaves no active trigger-mode burst
  a_r4_trig_clear: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TRIG && !trigger && $past(!trigger)) |-> !busy);

endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;

  localparam int PERIOD = 10;
  localparam int NV = 9;
  // {mode[1:0], count[7:0], falls[3:0], expBusy, expDone}
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 8'd3, 4'd4, 1'b0, 1'b1},  // R3 ends on count
    {2'd0, 8'd3, 4'd3, 1'b1, 1'b0},  // R3 one short
    {2'd1, 8'd2, 4'd3, 1'b0, 1'b1},  // R5 ends on count
    {2'd1, 8'd0, 4'd6, 1'b1, 1'b0},  // R6 continuous
    {2'd0, 8'd0, 4'd5, 1'b1, 1'b0},  // R6 continuous
    {2'd2, 8'd1, 4'd5, 1'b1, 1'b0},  // R7 count ignored
    {2'd3, 8'd2, 4'd3, 1'b0, 1'b1},  // R9 ends on count
    {2'd3, 8'd0, 4'd2, 1'b0, 1'b1},  // R9 zero acts as one
    {2'd3, 8'd5, 4'd4, 1'b1, 1'b0}   // R9 still running
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       trigger = 1'b0;
  logic [7:0] pulseCount = 8'd0;
  logic [7:0] blankCycles = 8'd0;
  logic       io1 = 1'b1;
  logic       io2 = 1'b1;
  logic       outA, outB, busy, burstDone;

  int nChk = 0;
  int nBad = 0;
  int doneCnt = 0;
  int doneDouble = 0;
  logic donePrev = 1'b0;
  bit finished = 0;

  burst_seq uut (
    .clk(clk), .rstN(rstN), .mode(mode), .trigger(trigger),
    .pulseCount(pulseCount), .blankCycles(blankCycles),
    .io1(io1), .io2(io2), .outA(outA), .outB(outB),
    .busy(busy), .burstDone(burstDone)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (burstDone) doneCnt++;
    if (burstDone && donePrev) doneDouble++;
    donePrev <= burstDone;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; io1 = 1'b1; io2 = 1'b1; trigger = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(2);
  endtask

  task automatic pulse2();
    io2 = 1'b0; tick(4);
    io2 = 1'b1; tick(4);
  endtask

  task automatic pulse1();
    io1 = 1'b0; tick(4);
    io1 = 1'b1; tick(4);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int d0;
    // R1 reset state
    tick(2);
    check("R1 busy in reset", busy, 0);
    check("R1 outA in reset", outA, 0);
    check("R1 outB in reset", outB, 0);
    check("R1 done in reset", burstDone, 0);
    rstN = 1'b1; tick(2);
    check("R1 busy after release", busy, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] vm; logic [7:0] vc; logic [3:0] vf; logic eb, ed;
      {vm, vc, vf, eb, ed} = VEC[i];
      doReset();
      mode = vm; pulseCount = vc; blankCycles = 8'd0;
      tick(1);
      d0 = doneCnt;
      case (vm)
        2'd0: begin trigger = 1'b1; tick(4); end
        2'd1: begin io1 = 1'b0; tick(4); end
        2'd2: begin io2 = 1'b0; tick(4); end
        default: ;
      endcase
      for (int k = 0; k < int'(vf); k++) begin
        if (vm == 2'd2) pulse1(); else pulse2();
      end
      check($sformatf("R3/R5/R6/R7/R9 busy row %0d", i), busy, eb);
      check($sformatf("R11 done row %0d", i), doneCnt - d0, ed);
      check($sformatf("R2 outA row %0d", i), outA, eb ? io1 : 1'b0);
      check($sformatf("R2 outB row %0d", i), outB, eb ? io2 : 1'b0);
    end

    // R2 follow with two-stage latency, mode 2 active
    doReset();
    mode = 2'd2; io2 = 1'b0; tick(4);
    io1 = 1'b0; tick(4);
    io1 = 1'b1; tick(3);
    check("R2 outA follows high", outA, 1);
    io1 = 1'b0; tick(3);
    check("R2 outA follows low", outA, 0);
    check("R2 outB follows low", outB, 0);

    // R4 re-arm needs low then high
    doReset();
    mode = 2'd0; pulseCount = 8'd1; tick(1);
    trigger = 1'b1; tick(4);
    pulse2(); pulse2();
    check("R3 count 1 ended", busy, 0);
    pulse2(); pulse2();
    check("R4 no re-arm while trigger high", busy, 0);
    trigger = 1'b0; tick(4);
    trigger = 1'b1; tick(4);
    pulse2();
    check("R4 re-armed after low-high", busy, 1);
    d0 = doneCnt;
    trigger = 1'b0; tick(4);
    check("R4 trigger clear ends", busy, 0);
    check("R11 done on trigger clear", doneCnt - d0, 1);
    pulse2();
    check("R4 edge while trigger low ignored", busy, 0);

    // R5 io1 rise ends, R6 continuous
    doReset();
    mode = 2'd1; pulseCount = 8'd0; tick(1);
    io1 = 1'b0; tick(4);
    pulse2(); pulse2(); pulse2();
    check("R6 continuous still busy", busy, 1);
    io1 = 1'b1; tick(4);
    check("R5 io1 rise ends", busy, 0);

    // R8 overlap
    doReset();
    mode = 2'd2; tick(1);
    io2 = 1'b0; tick(4);
    io1 = 1'b0; tick(4);
    io1 = 1'b1; tick(4);
    check("R7 started on io1 edge", busy, 1);
    d0 = doneCnt;
    io2 = 1'b1; tick(4);
    check("R8 overlap ends burst", busy, 0);
    check("R8 done on overlap", doneCnt - d0, 1);
    io1 = 1'b0; tick(4);
    check("R8 next edge only arms", busy, 0);
    io2 = 1'b0; tick(4);
    check("R7 io2 edge does not start", busy, 0);
    io1 = 1'b1; tick(4);
    io1 = 1'b0; tick(4);
    check("R8 later io1 edge starts", busy, 1);

    // R10 blank-out
    doReset();
    mode = 2'd3; pulseCount = 8'd1; blankCycles = 8'd20; tick(1);
    pulse2(); pulse2();
    check("R9 count 1 ended", busy, 0);
    io2 = 1'b0; tick(4);
    check("R10 edge in blank ignored", busy, 0);
    io2 = 1'b1; tick(30);
    io2 = 1'b0; tick(4);
    check("R10 start after blank", busy, 1);
    io2 = 1'b1; tick(4);

    check("R11 no stretched done", doneDouble, 0);
    finish();
  end

endmodule